// File: doc/BRIEF.md
# Pipelined Burst Memory with Wrapping Address Counter

This block is a single-port synchronous memory for a bus master that fetches or stores short bursts. The master gives one start address with a strobe. The block registers that address and then produces four consecutive accesses from it, one for each advance. The first access uses the start address. The other three come from a two-bit counter that wraps inside the aligned group of four words. A mode input picks either a counting order or an XOR-based interleaved order.

Read data passes through one output register. A word read in the cycle after the address is registered is therefore visible after the next rising edge. Writes can be limited to single 9-bit lanes through three levels of control: a global write, a lane-write enable, and one strobe per lane. A sleep input freezes the whole block without losing the stored contents.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, `rdata_o` is all zeros, `rvalid_o` is low and no burst is active.
- R2: A cycle with `start_i` high and `sleep_i` low registers `addr_i` and starts a burst at beat 0. The access for the registered address takes place on the next clock edge. For a read, the word appears on `rdata_o` with `rvalid_o` high after that edge.
- R3: With `ilv_i` low (linear order), the two low address bits of beat k equal (start low bits + k) mod 4. The upper address bits never change during a burst.
- R4: With `ilv_i` high (interleaved order), the two low address bits of beat k equal the start low bits XOR k. The upper bits are unchanged.
- R5: During an active burst, an edge with `adv_i` low still performs the access but keeps the same beat. The next access repeats the same address.
- R6: An edge with `adv_i` high on beat 3 ends the burst. After that no access happens and `rvalid_o` is low until a new start.
- R7: `wr_all_i` high writes all lanes of the current beat, whatever the values of `byte_wr_en_i` and `lane_wr_i`.
- R8: With `wr_all_i` low and `byte_wr_en_i` high, lane i (bits 9i+8..9i) is written only when `lane_wr_i[i]` is high. With both `wr_all_i` and `byte_wr_en_i` low, the access is a read.
- R9: An access that writes at least one lane leaves `rdata_o` unchanged and drives `rvalid_o` low after its edge.
- R10: While `sleep_i` is high, no write occurs and `rdata_o`, `rvalid_o` and the beat counter hold. Operation resumes from the held beat on the first edge after `sleep_i` falls.
- R11: A start during an active burst first performs the current beat's access on that edge. The following beats then come from the newly registered address.
- R12: The word is LANES lanes of 9 bits. LANES=4 gives 36 bits and LANES=2 gives 18 bits, and the same burst and lane rules apply to both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Address strobe: registers addr_i and starts a burst |
| addr_i | input | ADDR_W | Start word address |
| adv_i | input | 1 | Advance to next beat after this access |
| ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_i | input | 1 | Global write of every lane |
| byte_wr_en_i | input | 1 | Enables per-lane write strobes |
| lane_wr_i | input | LANES | Per-lane write strobes |
| sleep_i | input | 1 | Power-down freeze |
| wdata_i | input | 9*LANES | Write data for the current beat |
| rdata_o | output | 9*LANES | Registered read data |
| rvalid_o | output | 1 | rdata_o was loaded by the last access |

## Verification
The main instance uses ADDR_W=5 and LANES=4. With only 32 words, the bench fills the whole array with write bursts. It then reads a burst from every one of the 32 start addresses in both orders, so every low-bit combination, every aligned group and every wrap point is covered. It also applies all 16 lane-strobe patterns. A second instance with LANES=2 exercises the 18-bit configuration through a write burst and an interleaved read-back. The same small sizes make it possible to follow sleep, suspend and mid-burst restart word by word against a model in the bench.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    localparam int LANE_W = 9;
    localparam int BEATS  = 4;

    // Low address bits of a beat, linear or interleaved.
    function automatic logic [1:0] beat_lo(input logic [1:0] first,
                                           input logic [1:0] beat,
                                           input logic       ilv);
        return ilv ? (first ^ beat) : (first + beat);
    endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    input  logic              ilv_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic              active_o
);
    localparam int HI_W = ADDR_W - 2;
    localparam logic [1:0] LAST_BEAT = 2'(BEATS - 1);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [1:0]      first_lo;
        logic [1:0]      beat;
        logic            active;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!sleep_i) begin
            if (start_i) begin
                seq_d.hi       = addr_i[ADDR_W-1:2];
                seq_d.first_lo = addr_i[1:0];
                seq_d.beat     = 2'd0;
                seq_d.active   = 1'b1;
            end else if (seq_q.active && adv_i) begin
                if (seq_q.beat == LAST_BEAT) begin
                    seq_d.active = 1'b0;
                end
                seq_d.beat = seq_q.beat + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign eff_addr_o = {seq_q.hi, beat_lo(seq_q.first_lo, seq_q.beat, ilv_i)};
    assign active_o   = seq_q.active;
endmodule

// File: rtl/lane_mask.sv
module lane_mask #(
    parameter int LANES = 4
) (
    input  logic             wr_all_i,
    input  logic             byte_wr_en_i,
    input  logic [LANES-1:0] lane_wr_i,
    output logic [LANES-1:0] mask_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask_o[g] = wr_all_i | (byte_wr_en_i & lane_wr_i[g]);
    end
endmodule

// File: rtl/sram_array.sv
module sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     access_i,
    input  logic                     hold_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LANES-1:0]         mask_i,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    output logic [LANES*LANE_W-1:0]  rdata_o,
    output logic                     rvalid_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } out_t;

    out_t              out_d, out_q;
    logic [DATA_W-1:0] rd_word;
    logic              do_access;

    assign do_access = access_i && !hold_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        always_ff @(posedge clk) begin
            if (do_access && mask_i[g]) begin
                lane_mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end
        assign rd_word[g*LANE_W +: LANE_W] = lane_mem[addr_i];
    end

    always_comb begin
        out_d = out_q;
        if (!hold_i) begin
            if (do_access && (mask_i == '0)) begin
                out_d.rdata  = rd_word;
                out_d.rvalid = 1'b1;
            end else begin
                out_d.rvalid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata_o  = out_q.rdata;
    assign rvalid_o = out_q.rvalid;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    adv_i,
    input  logic                    ilv_i,
    input  logic                    wr_all_i,
    input  logic                    byte_wr_en_i,
    input  logic [LANES-1:0]        lane_wr_i,
    input  logic                    sleep_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvalid_o
);
    logic [ADDR_W-1:0] eff_addr;
    logic              seq_active;
    logic [LANES-1:0]  wmask;

    burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .adv_i      (adv_i),
        .ilv_i      (ilv_i),
        .eff_addr_o (eff_addr),
        .active_o   (seq_active)
    );

    lane_mask #(.LANES(LANES)) u_mask (
        .wr_all_i     (wr_all_i),
        .byte_wr_en_i (byte_wr_en_i),
        .lane_wr_i    (lane_wr_i),
        .mask_o       (wmask)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .access_i (seq_active),
        .hold_i   (sleep_i),
        .addr_i   (eff_addr),
        .mask_i   (wmask),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                adv_i,
    input logic                ilv_i,
    input logic                wr_all_i,
    input logic                byte_wr_en_i,
    input logic                sleep_i,
    input logic [LANES*9-1:0]  rdata_o,
    input logic                rvalid_o,
    input logic                active,
    input logic [ADDR_W-1:0]   eff_addr,
    input logic [LANES-1:0]    wmask
);
    // R2
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !sleep_i) |=> active);

    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start_i && !adv_i && !sleep_i) |=> (!$stable(ilv_i) || $stable(eff_addr)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !sleep_i) |=> !rvalid_o);

    // R8
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_i && !byte_wr_en_i) |-> (wmask == '0));

    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sleep_i && wr_all_i) |=> !rvalid_o);

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> ($stable(rdata_o) && $stable(rvalid_o)));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_out_chk: assert (!rvalid_o && rdata_o == '0 && !active);
        end
    end
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .adv_i        (adv_i),
    .ilv_i        (ilv_i),
    .wr_all_i     (wr_all_i),
    .byte_wr_en_i (byte_wr_en_i),
    .sleep_i      (sleep_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .active       (seq_active),
    .eff_addr     (eff_addr),
    .wmask        (wmask)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
    localparam int AW = 5;
    localparam int LN = 4;
    localparam int DW = LN * 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, adv = 0, ilv = 0, gw = 0, ben = 0, sleep = 0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] strb = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    logic start2 = 0, adv2 = 0, ilv2 = 0, gw2 = 0;
    logic [AW-1:0] addr2 = '0;
    logic [17:0]   wdata2 = '0;
    logic [17:0]   rdata2;
    logic          rvalid2;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [32];

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(LN)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .adv_i(adv),
        .ilv_i(ilv), .wr_all_i(gw), .byte_wr_en_i(ben), .lane_wr_i(strb),
        .sleep_i(sleep), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
    );

    burst_sram #(.ADDR_W(AW), .LANES(2)) dut2 (
        .clk(clk), .rst_n(rst_n), .start_i(start2), .addr_i(addr2), .adv_i(adv2),
        .ilv_i(ilv2), .wr_all_i(gw2), .byte_wr_en_i(1'b0), .lane_wr_i(2'b00),
        .sleep_i(1'b0), .wdata_i(wdata2), .rdata_o(rdata2), .rvalid_o(rvalid2)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k, input logic il);
        logic [1:0] lo;
        lo = il ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k));
        return {a[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(input int seed, input int k);
        logic [31:0] x;
        x = 32'(seed) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15 + 32'd99;
        return {4'(k + seed), x};
    endfunction

    // one full burst with advance held high; write when any lane is enabled
    task automatic burst(input logic [AW-1:0] a, input logic il, input logic g,
                         input logic be, input logic [LN-1:0] s, input int seed);
        logic [LN-1:0] m;
        logic [AW-1:0] ea;
        m = g ? '1 : (be ? s : '0);
        start = 1; addr = a; adv = 0; ilv = il; gw = 0; ben = 0; strb = '0;
        step();
        for (int k = 0; k < 4; k++) begin
            start = 0; adv = 1; gw = g; ben = be; strb = s; wdata = pat(seed, k);
            ea = beat_addr(a, k, il);
            step();
            if (m != '0) begin
                for (int l = 0; l < LN; l++)
                    if (m[l]) model[ea][l*9 +: 9] = wdata[l*9 +: 9];
                chk({35'd0, rvalid}, '0, "R9 write beat rvalid");
            end else begin
                chk(rdata, model[ea], il ? "R4 interleaved read" : "R3 linear read");
                chk({35'd0, rvalid}, 1, "R2 read rvalid");
            end
        end
        adv = 0; gw = 0; ben = 0; strb = '0;
        step();
        chk({35'd0, rvalid}, '0, "R6 burst ended");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        logic [AW-1:0] ea;
        @(negedge clk); step();
        chk(rdata, '0, "R1 reset rdata");
        chk({35'd0, rvalid}, '0, "R1 reset rvalid");
        rst_n = 1; step();

        // R7: fill with global writes
        for (int b = 0; b < 8; b++) burst(5'(b * 4), 0, 1, 0, '0, b);
        // R3 R4: every start, both orders
        for (int a = 0; a < 32; a++)
            for (int il = 0; il < 2; il++) burst(5'(a), il[0], 0, 0, '0, 0);
        // R7: global overrides disabled strobes
        burst(5'd5, 1, 1, 0, '0, 50);
        burst(5'd5, 0, 0, 0, '0, 0);
        // R8: every strobe pattern
        for (int m = 0; m < 16; m++) begin
            burst(5'((m * 3) % 32), 0, 0, 1, 4'(m), 100 + m);
            burst(5'((m * 3) % 32), 1, 0, 0, '0, 0);
        end
        // R8: strobes without enable read
        burst(5'd9, 0, 0, 0, '1, 7);

        // R5: suspend
        start = 1; addr = 5'd10; ilv = 0; step();
        start = 0; adv = 0;
        for (int r = 0; r < 2; r++) begin
            step();
            chk(rdata, model[5'd10], "R5 suspended beat");
        end
        adv = 1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(rdata, model[beat_addr(5'd10, k, 0)], "R5 resumed beat");
        end
        adv = 0; step();

        // R10: sleep
        start = 1; addr = 5'd14; ilv = 1; step();
        start = 0; adv = 1; step();
        held = rdata;
        chk(rdata, model[5'd14], "R10 pre-sleep read");
        sleep = 1; gw = 1; wdata = '1;
        for (int r = 0; r < 3; r++) begin
            step();
            chk(rdata, held, "R10 sleep holds rdata");
            chk({35'd0, rvalid}, 1, "R10 sleep holds rvalid");
        end
        sleep = 0; gw = 0;
        for (int k = 1; k < 4; k++) begin
            step();
            chk(rdata, model[beat_addr(5'd14, k, 1)], "R10 resume no write");
        end
        adv = 0; step();

        // R11: restart mid-burst
        start = 1; addr = 5'd20; ilv = 0; step();
        start = 0; adv = 1; step(); step();
        start = 1; addr = 5'd7; step();
        chk(rdata, model[5'd22], "R11 current beat completes");
        start = 0;
        for (int k = 0; k < 4; k++) begin
            step();
            ea = beat_addr(5'd7, k, 0);
            chk(rdata, model[ea], "R11 new burst beat");
        end
        adv = 0; step();

        // R12: 18-bit configuration
        start2 = 1; addr2 = 5'd4; ilv2 = 0; step();
        start2 = 0; adv2 = 1; gw2 = 1;
        for (int k = 0; k < 4; k++) begin
            wdata2 = 18'(k * 4099 + 77);
            step();
        end
        gw2 = 0; adv2 = 0; step();
        start2 = 1; addr2 = 5'd6; ilv2 = 1; step();
        start2 = 0; adv2 = 1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk({18'd0, rdata2}, {18'd0, 18'((((2 ^ k) & 3)) * 4099 + 77)}, "R12 narrow word");
        end
        adv2 = 0; step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule